// File: doc/BRIEF.md
# Hardwired Instruction-Cycle Sequencer

This block is the timing and control core of a 16-bit accumulator machine whose word memory holds 4096 words of 16 bits. A 4-bit step counter, decoded into one-hot step lines, walks each instruction through fetch, decode, optional indirect-address resolution and execution. The block holds the address, program-counter, instruction and data registers, the indirect flag and a 3-to-8 opcode decoder. It carries out the seven memory-reference instructions itself, in steps T4 to T6.

The accumulator and the register-reference and I/O functions live in neighbouring units. The sequencer gives them one-cycle strobes and exposes the instruction and data registers. It reads the accumulator through `ac_in` for stores. A neighbour can request a skip at step T3 through `ext_skip`. A `run` input gates all progress. A load port writes words into the included memory, so a bench can place programs and data.

Top module: `insn_sequencer`

## Requirements
- R1: In T0, AR takes PC and bus_sel shows 3'b010. In T1, IR takes M[AR], PC increments by one, and bus_sel shows 3'b111.
- R2: In T2, AR takes IR[11:0] and the indirect flag takes IR[15]. IR[14:12] selects the operation: 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ, 7 register-reference or I/O.
- R3: In T3, for opcodes 0 to 6, AR takes M[AR][11:0] when the indirect flag is 1, and AR is left unchanged when the flag is 0.
- R4: In T3, for opcode 7, reg_ref_stb pulses when IR[15]=0 and io_stb pulses when IR[15]=1. PC increments if ext_skip is 1, and the step counter returns to 0.
- R5: AND, ADD and LDA load DR from M[AR] in T4. In T5 they pulse ac_and_stb, ac_add_stb or ac_lda_stb respectively for one cycle, then the step counter returns to 0. At most one strobe or memory write is active in any cycle.
- R6: STA writes ac_in into M[AR] in T4 and ends the instruction.
- R7: BUN loads PC from AR in T4 and ends the instruction.
- R8: BSA writes the zero-extended PC into M[AR] and increments AR in T4. In T5 it loads PC from AR and ends the instruction.
- R9: ISZ loads DR from M[AR] in T4 and increments DR in T5. In T6 it writes DR back to M[AR], increments PC if DR is zero, and ends the instruction.
- R10: While run is 0, the step counter and all registers hold their values. A low rst_n at a clock edge clears the step counter, PC, AR, IR, DR and the indirect flag.
- R11: The step counter never passes 6.
- R12: While load_en is 1, load_data is written to M[load_addr]. mem_word always shows M[AR].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Start/stop flag; steps advance only while high |
| ac_in | input | 16 | Accumulator value from the arithmetic unit |
| ext_skip | input | 1 | Skip request from register-reference or I/O unit, sampled in T3 |
| load_en | input | 1 | Memory load strobe |
| load_addr | input | 12 | Memory load address |
| load_data | input | 16 | Memory load word |
| sc_out | output | 4 | Current step number |
| pc_out | output | 12 | Program counter |
| ar_out | output | 12 | Address register |
| ir_out | output | 16 | Instruction register |
| dr_out | output | 16 | Data register |
| ind_out | output | 1 | Indirect flag |
| bus_sel | output | 3 | Bus source code |
| mem_word | output | 16 | Memory word at AR |
| reg_ref_stb | output | 1 | Register-reference execute strobe |
| io_stb | output | 1 | I/O execute strobe |
| ac_and_stb | output | 1 | Accumulator AND-with-DR strobe |
| ac_add_stb | output | 1 | Accumulator add-DR strobe |
| ac_lda_stb | output | 1 | Accumulator load-from-DR strobe |

## Verification
On every cycle, the assertions check the fetch transfers, the decode transfer, direct-address hold and the BUN and BSA jump targets. They also check the end of register-reference and I/O instructions, that strobes and writes are exclusive, that steps hold while stopped, and the step ceiling. Only the bench scenarios can show what ends up in memory after STA, BSA and ISZ. The bench reads that back through mem_word and through a follow-on LDA. The bench also covers the ISZ skip on wrap to zero and indirect addressing for all seven opcodes, with both operand values.

// File: rtl/insn_seq_pkg.sv
// Package: shared constants for the instruction-cycle sequencer.
// Assumes a 3-bit opcode field and a 3-bit bus-source code.
package insn_seq_pkg;
    localparam int OPC_W = 3;
    localparam int BUS_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_AND = 3'd0,
        OPC_ADD = 3'd1,
        OPC_LDA = 3'd2,
        OPC_STA = 3'd3,
        OPC_BUN = 3'd4,
        OPC_BSA = 3'd5,
        OPC_ISZ = 3'd6,
        OPC_EXT = 3'd7
    } opcode_e;

    localparam logic [BUS_W-1:0] BUS_IDLE = 3'b000;
    localparam logic [BUS_W-1:0] BUS_PC   = 3'b010;
    localparam logic [BUS_W-1:0] BUS_MEM  = 3'b111;
endpackage

// File: rtl/step_timer.sv
// Step counter with one-hot step decode.
// Counts up while run is high, returns to zero on clr (when running).
// Assumes the owner never lets the count pass LAST_STEP.
module step_timer #(
    parameter int SC_W      = 4,
    parameter int LAST_STEP = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 clr,
    output logic [SC_W-1:0]      sc,
    output logic [LAST_STEP:0]   t
);
    // Purpose: advance or clear the step count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sc <= '0;
        else if (run) begin
            if (clr) sc <= '0;
            else     sc <= sc + {{(SC_W-1){1'b0}}, 1'b1};
        end
    end

    // Purpose: one-hot step lines for the steps the sequencer uses.
    for (genvar k = 0; k <= LAST_STEP; k++) begin : g_step
        assign t[k] = (sc == SC_W'(k));
    end

    AST_SC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> $stable(sc)); // R10
endmodule

// File: rtl/op_decoder.sv
// Binary-to-one-hot opcode decoder.
// Assumes a narrow code (2**IN_W outputs).
module op_decoder #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]        code,
    output logic [(1<<IN_W)-1:0]   dec
);
    // Purpose: raise exactly one output per code value.
    for (genvar k = 0; k < (1 << IN_W); k++) begin : g_dec
        assign dec[k] = (code == IN_W'(k));
    end
endmodule

// File: rtl/word_mem.sv
// Word memory: write at clock edge, read of the addressed word in the same step.
// The load port has priority over the core write; contents are not reset.
module word_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Purpose: store a loaded word or a core write.
    always_ff @(posedge clk) begin
        if (load_en)
            mem[load_addr] <= load_data;
        else if (we)
            mem[addr] <= wdata;
    end

    // Purpose: present the addressed word for capture at the step's edge.
    assign rdata = mem[addr];
endmodule

// File: rtl/insn_sequencer.sv
// Hardwired instruction-cycle sequencer.
// Runs fetch (T0-T1), decode (T2), indirect resolution or hand-off (T3)
// and the seven memory-reference operations (T4-T6).
// Assumes the accumulator and register/I-O units are external and act on strobes.
module insn_sequencer
    import insn_seq_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int SC_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WORD_W-1:0] ac_in,
    input  logic              ext_skip,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_data,
    output logic [SC_W-1:0]   sc_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] ar_out,
    output logic [WORD_W-1:0] ir_out,
    output logic [WORD_W-1:0] dr_out,
    output logic              ind_out,
    output logic [BUS_W-1:0]  bus_sel,
    output logic [WORD_W-1:0] mem_word,
    output logic              reg_ref_stb,
    output logic              io_stb,
    output logic              ac_and_stb,
    output logic              ac_add_stb,
    output logic              ac_lda_stb
);
    localparam int LAST_STEP = 6;
    localparam int N_OPS     = 1 << OPC_W;
    localparam int OPC_LSB   = WORD_W - 1 - OPC_W;
    localparam int PAD_W     = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] pc, ar;
    logic [WORD_W-1:0] ir, dr, mem_q, mem_wdata;
    logic              ind, sc_clr, mem_we;
    logic [SC_W-1:0]   sc;
    logic [LAST_STEP:0] t;
    logic [N_OPS-1:0]  d;

    step_timer #(.SC_W(SC_W), .LAST_STEP(LAST_STEP)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(sc_clr), .sc(sc), .t(t)
    );

    op_decoder #(.IN_W(OPC_W)) u_dec (
        .code(ir[WORD_W-2:OPC_LSB]), .dec(d)
    );

    word_mem #(.AW(ADDR_W), .DW(WORD_W)) u_mem (
        .clk(clk), .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .we(mem_we), .addr(ar), .wdata(mem_wdata), .rdata(mem_q)
    );

    // Purpose: the last step of each instruction class returns the counter to T0.
    assign sc_clr = (t[3] & d[OPC_EXT])
                  | (t[4] & (d[OPC_STA] | d[OPC_BUN]))
                  | (t[5] & (d[OPC_AND] | d[OPC_ADD] | d[OPC_LDA] | d[OPC_BSA]))
                  | (t[6] & d[OPC_ISZ]);

    // Purpose: memory write enable and data for STA, BSA and ISZ.
    assign mem_we = run & ((t[4] & (d[OPC_STA] | d[OPC_BSA])) | (t[6] & d[OPC_ISZ]));

    always_comb begin
        if (d[OPC_STA])      mem_wdata = ac_in;
        else if (d[OPC_BSA]) mem_wdata = {{PAD_W{1'b0}}, pc};
        else                 mem_wdata = dr;
    end

    // Purpose: bus source code for the fetch transfers.
    always_comb begin
        if (t[0])      bus_sel = BUS_PC;
        else if (t[1]) bus_sel = BUS_MEM;
        else           bus_sel = BUS_IDLE;
    end

    // Purpose: strobes to the accumulator and register/I-O units.
    assign reg_ref_stb = run & t[3] & d[OPC_EXT] & ~ind;
    assign io_stb      = run & t[3] & d[OPC_EXT] &  ind;
    assign ac_and_stb  = run & t[5] & d[OPC_AND];
    assign ac_add_stb  = run & t[5] & d[OPC_ADD];
    assign ac_lda_stb  = run & t[5] & d[OPC_LDA];

    // Purpose: register transfers for every step of the instruction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc  <= '0;
            ar  <= '0;
            ir  <= '0;
            dr  <= '0;
            ind <= 1'b0;
        end else if (run) begin
            if (t[0]) ar <= pc;
            if (t[1]) begin
                ir <= mem_q;
                pc <= pc + 1'b1;
            end
            if (t[2]) begin
                ar  <= ir[ADDR_W-1:0];
                ind <= ir[WORD_W-1];
            end
            if (t[3]) begin
                if (d[OPC_EXT]) begin
                    if (ext_skip) pc <= pc + 1'b1;
                end else if (ind) begin
                    ar <= mem_q[ADDR_W-1:0];
                end
            end
            if (t[4]) begin
                if (d[OPC_AND] | d[OPC_ADD] | d[OPC_LDA] | d[OPC_ISZ]) dr <= mem_q;
                if (d[OPC_BUN]) pc <= ar;
                if (d[OPC_BSA]) ar <= ar + 1'b1;
            end
            if (t[5]) begin
                if (d[OPC_BSA]) pc <= ar;
                if (d[OPC_ISZ]) dr <= dr + 1'b1;
            end
            if (t[6] && d[OPC_ISZ] && (dr == '0)) pc <= pc + 1'b1;
        end
    end

    assign sc_out  = sc;
    assign pc_out  = pc;
    assign ar_out  = ar;
    assign ir_out  = ir;
    assign dr_out  = dr;
    assign ind_out = ind;
    assign mem_word = mem_q;

    AST_FETCH_AR: assert property (@(posedge clk) disable iff (!rst_n)
        (run && t[0]) |=> (ar == $past(pc))); // R1
    AST_FETCH_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (run && t[1]) |=> (pc == $past(pc) + 1'b1)); // R1
    AST_DECODE_EA: assert property (@(posedge clk) disable iff (!rst_n)
        (run && t[2]) |=> (ar == $past(ir[ADDR_W-1:0]) && ind == $past(ir[WORD_W-1]))); // R2
    AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && t[3] && !d[OPC_EXT] && !ind) |=> $stable(ar)); // R3
    AST_EXT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (run && t[3] && d[OPC_EXT]) |=> (sc == '0)); // R4
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_ref_stb, io_stb, ac_and_stb, ac_add_stb, ac_lda_stb, mem_we})); // R5
    AST_BUN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && t[4] && d[OPC_BUN]) |=> (pc == $past(ar) && sc == '0)); // R7
    AST_BSA_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (run && t[5] && d[OPC_BSA]) |=> (pc == $past(ar) && sc == '0)); // R8
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(!rst_n)) |=> ($stable(pc) && $stable(ir) && $stable(dr))); // R10
    AST_SC_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (sc <= SC_W'(LAST_STEP))); // R11
endmodule

// File: tb/insn_sequencer_test.sv
module insn_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [15:0] ac_in = 16'h0;
    logic        ext_skip = 1'b0;
    logic        load_en = 1'b0;
    logic [11:0] load_addr = 12'h0;
    logic [15:0] load_data = 16'h0;
    logic [3:0]  sc_out;
    logic [11:0] pc_out, ar_out;
    logic [15:0] ir_out, dr_out, mem_word;
    logic        ind_out, reg_ref_stb, io_stb, ac_and_stb, ac_add_stb, ac_lda_stb;
    logic [2:0]  bus_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    insn_sequencer uut (
        .clk(clk), .rst_n(rst_n), .run(run), .ac_in(ac_in), .ext_skip(ext_skip),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .sc_out(sc_out), .pc_out(pc_out), .ar_out(ar_out), .ir_out(ir_out),
        .dr_out(dr_out), .ind_out(ind_out), .bus_sel(bus_sel), .mem_word(mem_word),
        .reg_ref_stb(reg_ref_stb), .io_stb(io_stb), .ac_and_stb(ac_and_stb),
        .ac_add_stb(ac_add_stb), .ac_lda_stb(ac_lda_stb)
    );

    task automatic chk(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] v);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk);
        run = 1'b0; rst_n = 1'b0;
        tick(); tick();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic go();
        @(negedge clk);
        run = 1'b1;
    endtask

    // Fetch, decode and T3 for an instruction at address 0 whose field is 0x020.
    task automatic front(input logic [15:0] insn, input logic [11:0] ea, input bit ext);
        chk("R1", "bus at T0", {29'd0, bus_sel}, 32'h2);
        tick();
        chk("R1", "AR after T0", {20'd0, ar_out}, 32'h0);
        chk("R1", "bus at T1", {29'd0, bus_sel}, 32'h7);
        tick();
        chk("R1", "IR after T1", {16'd0, ir_out}, {16'd0, insn});
        chk("R1", "PC after T1", {20'd0, pc_out}, 32'h1);
        tick();
        chk("R2", "AR after T2", {20'd0, ar_out}, 32'h020);
        chk("R2", "I after T2", {31'd0, ind_out}, {31'd0, insn[15]});
        if (!ext) begin
            tick();
            chk("R3", "AR after T3", {20'd0, ar_out}, {20'd0, ea});
        end
    endtask

    initial begin
        restart();
        chk("R10", "reset SC", {28'd0, sc_out}, 32'h0);
        chk("R10", "reset PC", {20'd0, pc_out}, 32'h0);
        chk("R10", "reset DR", {16'd0, dr_out}, 32'h0);

        for (int op = 0; op < 7; op++) begin
            for (int ib = 0; ib < 2; ib++) begin
                for (int vi = 0; vi < 2; vi++) begin
                    logic [15:0] v, insn, sum;
                    logic [11:0] ea;
                    v    = (vi == 0) ? 16'hFFFF : 16'h1234;
                    insn = {ib[0], op[2:0], 12'h020};
                    ea   = ib[0] ? 12'h040 : 12'h020;
                    ac_in = 16'hA000 | {4'h0, op[3:0], ib[3:0], vi[3:0]};
                    poke(12'h000, insn);
                    if (ib[0]) poke(12'h020, 16'h0040);
                    poke(ea, v);
                    poke(ea + 12'd1, {4'h2, ea});
                    restart();
                    go();
                    front(insn, ea, 1'b0);
                    tick(); // T4 edge
                    case (op)
                        0, 1, 2: begin
                            chk("R5", "DR after T4", {16'd0, dr_out}, {16'd0, v});
                            chk("R5", "AND strobe", {31'd0, ac_and_stb}, {31'd0, op == 0});
                            chk("R5", "ADD strobe", {31'd0, ac_add_stb}, {31'd0, op == 1});
                            chk("R5", "LDA strobe", {31'd0, ac_lda_stb}, {31'd0, op == 2});
                            tick();
                            chk("R5", "end after T5", {28'd0, sc_out}, 32'h0);
                            chk("R5", "strobes cleared",
                                {29'd0, ac_and_stb, ac_add_stb, ac_lda_stb}, 32'h0);
                        end
                        3: begin
                            chk("R6", "end after T4", {28'd0, sc_out}, 32'h0);
                            chk("R6", "stored word", {16'd0, mem_word}, {16'd0, ac_in});
                        end
                        4: begin
                            chk("R7", "PC after T4", {20'd0, pc_out}, {20'd0, ea});
                            chk("R7", "end after T4", {28'd0, sc_out}, 32'h0);
                        end
                        5: begin
                            chk("R8", "AR after T4", {20'd0, ar_out}, {20'd0, ea + 12'd1});
                            tick();
                            chk("R8", "PC after T5", {20'd0, pc_out}, {20'd0, ea + 12'd1});
                            chk("R8", "end after T5", {28'd0, sc_out}, 32'h0);
                            for (int k = 0; k < 5; k++) tick();
                            chk("R8", "saved return address", {16'd0, dr_out}, 32'h1);
                        end
                        default: begin
                            sum = v + 16'd1;
                            chk("R9", "DR after T4", {16'd0, dr_out}, {16'd0, v});
                            tick();
                            chk("R9", "DR after T5", {16'd0, dr_out}, {16'd0, sum});
                            tick();
                            chk("R9", "end after T6", {28'd0, sc_out}, 32'h0);
                            chk("R9", "written back", {16'd0, mem_word}, {16'd0, sum});
                            chk("R9", "skip on zero", {20'd0, pc_out},
                                (sum == 16'h0) ? 32'h2 : 32'h1);
                        end
                    endcase
                end
            end
        end

        // Register-reference and I/O hand-off with and without skip, plus stop hold.
        for (int ib = 0; ib < 2; ib++) begin
            for (int sk = 0; sk < 2; sk++) begin
                logic [15:0] insn;
                insn = {ib[0], 3'b111, 4'h0, 8'h20 | {6'd0, sk[1:0]}};
                insn[11:0] = 12'h020;
                poke(12'h000, insn);
                restart();
                ext_skip = sk[0];
                go();
                tick(); tick();
                @(negedge clk); run = 1'b0;
                tick(); tick(); tick();
                chk("R10", "SC held while stopped", {28'd0, sc_out}, 32'h2);
                chk("R10", "PC held while stopped", {20'd0, pc_out}, 32'h1);
                chk("R10", "no strobe while stopped", {30'd0, reg_ref_stb, io_stb}, 32'h0);
                @(negedge clk); run = 1'b1;
                tick(); // T2 edge
                chk("R2", "I flag", {31'd0, ind_out}, {31'd0, ib[0]});
                chk("R4", "reg-ref strobe", {31'd0, reg_ref_stb}, {31'd0, ib == 0});
                chk("R4", "I/O strobe", {31'd0, io_stb}, {31'd0, ib == 1});
                tick();
                chk("R4", "end after T3", {28'd0, sc_out}, 32'h0);
                chk("R4", "skip", {20'd0, pc_out}, (sk == 1) ? 32'h2 : 32'h1);
                chk("R11", "strobes off at T0", {30'd0, reg_ref_stb, io_stb}, 32'h0);
                ext_skip = 1'b0;
            end
        end

        // Load port: write a word, then fetch it and see it in IR.
        poke(12'h000, 16'h4ABC);
        restart();
        go();
        tick(); tick();
        chk("R12", "loaded word fetched", {16'd0, ir_out}, 32'h4ABC);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule